// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block predicts, at fetch time, whether the instruction at the fetch address is a branch, where it goes and whether it will be taken. The fetch address is looked up combinationally across every way of one set in the same cycle as the instruction fetch. A hit returns the stored target, a two-bit branch kind and a taken/not-taken call. A miss is read as a fall-through prediction.

When a branch resolves later in the pipeline, the resolution port delivers the branch address, the real outcome, the real target and the branch kind. It also carries the prediction that fetch made for that branch. The block writes its storage from this port. It compares the carried prediction with the real outcome, and one cycle later it pulses a flush with the address fetch must restart from.

Only part of the address is kept as a tag. Two branches that differ only above the tag bits share one entry. This costs accuracy only, because any wrong prediction is caught at resolution. Each entry also keeps a two-bit saturating confidence counter that conditional branches use for their direction.

Top module: `btb_core`

## Requirements
- R1: A lookup that matches no valid entry drives `lk_hit` and `lk_taken` low, and sets `lk_next_pc` to `lk_pc + 4`.
- R2: A resolution that misses the buffer allocates an entry only when `rs_taken` is 1. A not-taken miss leaves every set unchanged.
- R3: A lookup hit returns the stored target on `lk_target` and the stored kind on `lk_type`. When the prediction is taken, `lk_next_pc` equals that target; otherwise it equals `lk_pc + 4`.
- R4: Kind codes are 0 conditional, 1 return, 2 call and 3 unconditional. A hit of kind 1, 2 or 3 always predicts taken.
- R5: A hit of kind 0 predicts taken exactly when bit 1 of the entry's counter is set. A new entry's counter starts at binary 10. Each resolution that hits the entry moves the counter up by one on taken and down by one on not-taken, saturating at 3 and 0.
- R6: A resolution that hits an existing entry rewrites that same entry with the new target, kind and counter. It never creates a second copy.
- R7: An allocation takes the lowest-numbered invalid way of the set. If no way is invalid, it takes the way after the one most recently written in that set, modulo the way count.
- R8: The set index is taken from address bits starting at bit 2, and the tag from the bits just above the index. Addresses that agree in those bits hit the same entry.
- R9: A resolution asserts `flush` in the following cycle, for one cycle, in three cases: predicted not-taken but taken; predicted taken but not taken; or predicted and actually taken with a different target. `redirect_pc` is then the real target if taken, else `rs_pc + 4`. No flush is raised otherwise.
- R10: After synchronous reset every entry is invalid and `flush` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Fetch address to look up |
| lk_hit | output | 1 | Fetch address matches a valid entry |
| lk_taken | output | 1 | Predicted taken |
| lk_type | output | 2 | Stored branch kind (0 if miss) |
| lk_target | output | PC_W | Stored target (0 if miss) |
| lk_next_pc | output | PC_W | Predicted next fetch address |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | PC_W | Address of the resolving branch |
| rs_taken | input | 1 | Real direction |
| rs_target | input | PC_W | Real target |
| rs_type | input | 2 | Branch kind |
| rs_pred_taken | input | 1 | Direction predicted at fetch |
| rs_pred_target | input | PC_W | Next address predicted at fetch |
| flush | output | 1 | Misprediction, restart fetch |
| redirect_pc | output | PC_W | Address to restart fetch from |

## Verification
The bench works on a four-set, four-way buffer with three-bit tags. A long pseudo-random branch stream drives it, with heavy set pressure and frequent aliasing, and the bench keeps an arithmetic model of sets, counters and victim pointers to compare against.

Each corner case has a visible symptom when the design gets it wrong:
- Allocating on a not-taken miss would show up as a later unexpected hit.
- A counter that does not saturate, or that starts at the wrong value, would flip a conditional prediction one resolution early or late.
- A duplicate entry on update, or a wrong victim choice, would show up as a stale target or a surviving entry that should have been evicted.
- Confusing the three misprediction cases would show up as a missing flush or a wrong redirect, most visibly for a taken branch whose target changed.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        BR_COND   = 2'd0,
        BR_RET    = 2'd1,
        BR_CALL   = 2'd2,
        BR_UNCOND = 2'd3
    } btype_e;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_ALLOC = 2'b10;

    function automatic ctr2_t ctr_next(input ctr2_t c, input logic taken);
        ctr2_t r;
        if (taken) r = (c == 2'b11) ? c : c + 2'd1;
        else       r = (c == 2'b00) ? c : c - 2'd1;
        return r;
    endfunction

    function automatic logic dir_taken(input btype_e t, input ctr2_t c);
        return (t != BR_COND) || c[1];
    endfunction

endpackage

// File: rtl/btb_way.sv
module btb_way #(
    parameter int SETS  = 128,
    parameter int TAG_W = 8,
    parameter int PC_W  = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     ra_idx,
    output logic                 ra_valid,
    output logic [TAG_W-1:0]     ra_tag,
    output logic [PC_W-1:0]      ra_target,
    output btb_pkg::btype_e      ra_type,
    output btb_pkg::ctr2_t       ra_ctr,
    input  logic [IDX_W-1:0]     rb_idx,
    output logic                 rb_valid,
    output logic [TAG_W-1:0]     rb_tag,
    output btb_pkg::ctr2_t       rb_ctr,
    input  logic                 we,
    input  logic [IDX_W-1:0]     w_idx,
    input  logic [TAG_W-1:0]     w_tag,
    input  logic [PC_W-1:0]      w_target,
    input  btb_pkg::btype_e      w_type,
    input  btb_pkg::ctr2_t       w_ctr
);
    logic [SETS-1:0]    vld_q;
    logic [TAG_W-1:0]   tag_q [SETS];
    logic [PC_W-1:0]    tgt_q [SETS];
    btb_pkg::btype_e    typ_q [SETS];
    btb_pkg::ctr2_t     ctr_q [SETS];

    always_ff @(posedge clk) begin
        if (rst)     vld_q <= '0;
        else if (we) vld_q[w_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (we) begin
            tag_q[w_idx] <= w_tag;
            tgt_q[w_idx] <= w_target;
            typ_q[w_idx] <= w_type;
            ctr_q[w_idx] <= w_ctr;
        end
    end

    assign ra_valid  = vld_q[ra_idx];
    assign ra_tag    = tag_q[ra_idx];
    assign ra_target = tgt_q[ra_idx];
    assign ra_type   = typ_q[ra_idx];
    assign ra_ctr    = ctr_q[ra_idx];
    assign rb_valid  = vld_q[rb_idx];
    assign rb_tag    = tag_q[rb_idx];
    assign rb_ctr    = ctr_q[rb_idx];
endmodule

// File: rtl/btb_repl.sv
module btb_repl #(
    parameter int SETS = 128,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  q_idx,
    output logic [WAY_W-1:0]  victim,
    input  logic              touch,
    input  logic [IDX_W-1:0]  t_idx,
    input  logic [WAY_W-1:0]  t_way
);
    logic [WAY_W-1:0] ptr_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (touch) begin
            ptr_q[t_idx] <= t_way + WAY_W'(1);
        end
    end

    assign victim = ptr_q[q_idx];

    // R7
    victim_follows_touch_chk: assert property (@(posedge clk) disable iff (rst)
        (touch && q_idx == t_idx) |=> (victim == $past(t_way) + WAY_W'(1) || q_idx != $past(t_idx)));
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve #(
    parameter int PC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rs_valid,
    input  logic [PC_W-1:0]  rs_pc,
    input  logic             rs_taken,
    input  logic [PC_W-1:0]  rs_target,
    input  logic             rs_pred_taken,
    input  logic [PC_W-1:0]  rs_pred_target,
    output logic             flush,
    output logic [PC_W-1:0]  redirect_pc
);
    logic wrong_dir, wrong_tgt, miss_now;

    assign wrong_dir = rs_pred_taken != rs_taken;
    assign wrong_tgt = rs_pred_taken && rs_taken && (rs_pred_target != rs_target);
    assign miss_now  = rs_valid && (wrong_dir || wrong_tgt);

    always_ff @(posedge clk) begin
        if (rst) begin
            flush       <= 1'b0;
            redirect_pc <= '0;
        end else begin
            flush <= miss_now;
            if (miss_now) redirect_pc <= rs_taken ? rs_target : rs_pc + PC_W'(4);
        end
    end

    // R9
    flush_needs_update_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> $past(rs_valid));
    // R9
    redirect_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (flush && $past(rs_taken)) |-> redirect_pc == $past(rs_target));
    // R9
    correct_pred_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && rs_pred_taken == rs_taken && (!rs_taken || rs_pred_target == rs_target)) |=> !flush);
endmodule

// File: rtl/btb_core.sv
module btb_core #(
    parameter int PC_W  = 32,
    parameter int SETS  = 128,
    parameter int WAYS  = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_hit,
    output logic             lk_taken,
    output logic [1:0]       lk_type,
    output logic [PC_W-1:0]  lk_target,
    output logic [PC_W-1:0]  lk_next_pc,
    input  logic             rs_valid,
    input  logic [PC_W-1:0]  rs_pc,
    input  logic             rs_taken,
    input  logic [PC_W-1:0]  rs_target,
    input  logic [1:0]       rs_type,
    input  logic             rs_pred_taken,
    input  logic [PC_W-1:0]  rs_pred_target,
    output logic             flush,
    output logic [PC_W-1:0]  redirect_pc
);
    import btb_pkg::*;

    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int IDX_LO = 2;
    localparam int TAG_LO = IDX_LO + IDX_W;

    logic [IDX_W-1:0] lk_idx, rs_idx;
    logic [TAG_W-1:0] lk_tag, rs_tag;

    assign lk_idx = lk_pc[TAG_LO-1:IDX_LO];
    assign lk_tag = lk_pc[TAG_LO+TAG_W-1:TAG_LO];
    assign rs_idx = rs_pc[TAG_LO-1:IDX_LO];
    assign rs_tag = rs_pc[TAG_LO+TAG_W-1:TAG_LO];

    logic [WAYS-1:0]  a_valid, b_valid, lk_match, rs_match, way_we;
    logic [TAG_W-1:0] a_tag [WAYS];
    logic [TAG_W-1:0] b_tag [WAYS];
    logic [PC_W-1:0]  a_target [WAYS];
    btype_e           a_type [WAYS];
    ctr2_t            a_ctr [WAYS];
    ctr2_t            b_ctr [WAYS];

    logic             wr_en;
    logic [WAY_W-1:0] wr_way, victim;
    ctr2_t            wr_ctr;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        btb_way #(.SETS(SETS), .TAG_W(TAG_W), .PC_W(PC_W)) u_way (
            .clk       (clk),
            .rst       (rst),
            .ra_idx    (lk_idx),
            .ra_valid  (a_valid[w]),
            .ra_tag    (a_tag[w]),
            .ra_target (a_target[w]),
            .ra_type   (a_type[w]),
            .ra_ctr    (a_ctr[w]),
            .rb_idx    (rs_idx),
            .rb_valid  (b_valid[w]),
            .rb_tag    (b_tag[w]),
            .rb_ctr    (b_ctr[w]),
            .we        (way_we[w]),
            .w_idx     (rs_idx),
            .w_tag     (rs_tag),
            .w_target  (rs_target),
            .w_type    (btype_e'(rs_type)),
            .w_ctr     (wr_ctr)
        );
        assign lk_match[w] = a_valid[w] && (a_tag[w] == lk_tag);
        assign rs_match[w] = b_valid[w] && (b_tag[w] == rs_tag);
        assign way_we[w]   = wr_en && (wr_way == WAY_W'(w));
    end

    btb_repl #(.SETS(SETS), .WAYS(WAYS)) u_repl (
        .clk    (clk),
        .rst    (rst),
        .q_idx  (rs_idx),
        .victim (victim),
        .touch  (wr_en),
        .t_idx  (rs_idx),
        .t_way  (wr_way)
    );

    btb_resolve #(.PC_W(PC_W)) u_resolve (
        .clk            (clk),
        .rst            (rst),
        .rs_valid       (rs_valid),
        .rs_pc          (rs_pc),
        .rs_taken       (rs_taken),
        .rs_target      (rs_target),
        .rs_pred_taken  (rs_pred_taken),
        .rs_pred_target (rs_pred_target),
        .flush          (flush),
        .redirect_pc    (redirect_pc)
    );

    // lookup side: lowest matching way wins
    logic [WAY_W-1:0] lk_way;
    always_comb begin
        lk_hit = 1'b0;
        lk_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (lk_match[w]) begin
                lk_hit = 1'b1;
                lk_way = WAY_W'(w);
            end
        end
    end

    assign lk_taken   = lk_hit && dir_taken(a_type[lk_way], a_ctr[lk_way]);
    assign lk_type    = lk_hit ? 2'(a_type[lk_way]) : 2'b00;
    assign lk_target  = lk_hit ? a_target[lk_way] : '0;
    assign lk_next_pc = lk_taken ? a_target[lk_way] : lk_pc + PC_W'(4);

    // resolution side: hit way, first free way, then victim
    logic             rs_hit, any_free;
    logic [WAY_W-1:0] rs_way, free_way;
    always_comb begin
        rs_hit   = 1'b0;
        rs_way   = '0;
        any_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (rs_match[w]) begin
                rs_hit = 1'b1;
                rs_way = WAY_W'(w);
            end
            if (!b_valid[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

    assign wr_en  = rs_valid && (rs_hit || rs_taken);
    assign wr_way = rs_hit ? rs_way : (any_free ? free_way : victim);
    assign wr_ctr = rs_hit ? ctr_next(b_ctr[rs_way], rs_taken) : CTR_ALLOC;

    // R1
    miss_falls_through_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (!lk_taken && lk_next_pc == lk_pc + PC_W'(4)));
    // R4
    fixed_kind_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_type != 2'(BR_COND)) |-> lk_taken);
    // R2
    alloc_only_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && !rs_hit) |-> ((way_we != '0) == rs_taken));
    // R6
    single_write_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_we));
    // R6
    rewrite_in_place_chk: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && rs_hit) |-> ((way_we & rs_match) == way_we && way_we != '0));
    // R7
    free_way_first_chk: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && !rs_hit && rs_taken && !(&b_valid)) |-> ((way_we & b_valid) == '0));
endmodule

// File: tb/sim_btb_core.sv
module sim_btb_core;
    localparam int CLK_PERIOD = 10;
    localparam int NSETS = 4;
    localparam int NWAYS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] lk_pc = '0;
    logic        lk_hit, lk_taken;
    logic [1:0]  lk_type;
    logic [15:0] lk_target, lk_next_pc;
    logic        rs_valid = 1'b0;
    logic [15:0] rs_pc = '0;
    logic        rs_taken = 1'b0;
    logic [15:0] rs_target = '0;
    logic [1:0]  rs_type = '0;
    logic        rs_pred_taken = 1'b0;
    logic [15:0] rs_pred_target = '0;
    logic        flush;
    logic [15:0] redirect_pc;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btb_core #(.PC_W(16), .SETS(NSETS), .WAYS(NWAYS), .TAG_W(3)) u0 (
        .clk(clk), .rst(rst),
        .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_type(lk_type),
        .lk_target(lk_target), .lk_next_pc(lk_next_pc),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target),
        .rs_type(rs_type), .rs_pred_taken(rs_pred_taken), .rs_pred_target(rs_pred_target),
        .flush(flush), .redirect_pc(redirect_pc)
    );

    // reference model: index = pc[3:2], tag = pc[6:4]
    bit          m_v   [NSETS][NWAYS];
    logic [2:0]  m_tag [NSETS][NWAYS];
    logic [15:0] m_tgt [NSETS][NWAYS];
    logic [1:0]  m_typ [NSETS][NWAYS];
    logic [1:0]  m_ctr [NSETS][NWAYS];
    int          m_ptr [NSETS];

    function automatic int m_find(input logic [15:0] pc);
        int s = int'(pc[3:2]);
        for (int k = 0; k < NWAYS; k++)
            if (m_v[s][k] && m_tag[s][k] == pc[6:4]) return k;
        return -1;
    endfunction

    function automatic void m_update(input logic [15:0] pc, input logic tk,
                                     input logic [15:0] tg, input logic [1:0] ty);
        int s = int'(pc[3:2]);
        int w = m_find(pc);
        if (w >= 0) begin
            m_tgt[s][w] = tg;
            m_typ[s][w] = ty;
            if (tk) m_ctr[s][w] = (m_ctr[s][w] == 2'd3) ? 2'd3 : m_ctr[s][w] + 2'd1;
            else    m_ctr[s][w] = (m_ctr[s][w] == 2'd0) ? 2'd0 : m_ctr[s][w] - 2'd1;
            m_ptr[s] = (w + 1) % NWAYS;
        end else if (tk) begin
            for (int k = 0; k < NWAYS; k++) if (!m_v[s][k] && w < 0) w = k;
            if (w < 0) w = m_ptr[s];
            m_v[s][w] = 1'b1;
            m_tag[s][w] = pc[6:4];
            m_tgt[s][w] = tg;
            m_typ[s][w] = ty;
            m_ctr[s][w] = 2'b10;
            m_ptr[s] = (w + 1) % NWAYS;
        end
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_look(input logic [15:0] pc);
        @(negedge clk);
        lk_pc = pc;
        #1;
    endtask

    // compare a lookup against the model; returns the model prediction
    task automatic look_model(input logic [15:0] pc, output logic pt, output logic [15:0] pn);
        int s, w;
        do_look(pc);
        s = int'(pc[3:2]);
        w = m_find(pc);
        if (w < 0) begin
            pt = 1'b0;
            pn = pc + 16'd4;
            chk("R1 miss hit", 32'(lk_hit), 0);
            chk("R1 miss next_pc", 32'(lk_next_pc), 32'(pn));
        end else begin
            pt = (m_typ[s][w] != 2'd0) || m_ctr[s][w][1];
            pn = pt ? m_tgt[s][w] : pc + 16'd4;
            chk("R8 hit", 32'(lk_hit), 1);
            chk("R3 target", 32'(lk_target), 32'(m_tgt[s][w]));
            chk("R3 type", 32'(lk_type), 32'(m_typ[s][w]));
            if (m_typ[s][w] != 2'd0) chk("R4 taken", 32'(lk_taken), 32'(pt));
            else                     chk("R5 taken", 32'(lk_taken), 32'(pt));
            chk("R3 next_pc", 32'(lk_next_pc), 32'(pn));
        end
    endtask

    task automatic resolve(input logic [15:0] pc, input logic tk, input logic [15:0] tg,
                           input logic [1:0] ty, input logic pt, input logic [15:0] ptg);
        logic ef;
        ef = (pt != tk) || (pt && tk && ptg != tg);
        @(negedge clk);
        rs_pc = pc; rs_taken = tk; rs_target = tg; rs_type = ty;
        rs_pred_taken = pt; rs_pred_target = ptg; rs_valid = 1'b1;
        @(negedge clk);
        rs_valid = 1'b0;
        chk("R9 flush", 32'(flush), 32'(ef));
        if (ef) chk("R9 redirect", 32'(redirect_pc), 32'(tk ? tg : pc + 16'd4));
        m_update(pc, tk, tg, ty);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic pt;
        logic [15:0] pn;
        logic [15:0] r;
        for (int s = 0; s < NSETS; s++) begin
            m_ptr[s] = 0;
            for (int k = 0; k < NWAYS; k++) m_v[s][k] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: empty after reset
        do_look(16'h0010);
        chk("R10 hit after reset", 32'(lk_hit), 0);
        chk("R10 flush after reset", 32'(flush), 0);

        // R2: not-taken miss allocates nothing
        resolve(16'h0010, 1'b0, 16'h0800, 2'd0, 1'b0, 16'h0014);
        do_look(16'h0010);
        chk("R2 no alloc on not-taken", 32'(lk_hit), 0);

        // R5: allocate at weakly taken
        resolve(16'h0010, 1'b1, 16'h0800, 2'd0, 1'b0, 16'h0014);
        do_look(16'h0010);
        chk("R5 init taken", 32'(lk_taken), 1);
        chk("R3 next_pc target", 32'(lk_next_pc), 32'h0800);

        // R9: predicted taken, went not-taken
        resolve(16'h0010, 1'b0, 16'h0800, 2'd0, 1'b1, 16'h0800);
        do_look(16'h0010);
        chk("R5 weak not-taken", 32'(lk_taken), 0);
        chk("R5 fall-through", 32'(lk_next_pc), 32'h0014);

        // R5: saturation at 0 then climb
        resolve(16'h0010, 1'b0, 16'h0800, 2'd0, 1'b0, 16'h0014);
        resolve(16'h0010, 1'b0, 16'h0800, 2'd0, 1'b0, 16'h0014);
        resolve(16'h0010, 1'b1, 16'h0800, 2'd0, 1'b0, 16'h0014);
        do_look(16'h0010);
        chk("R5 saturated low", 32'(lk_taken), 0);
        resolve(16'h0010, 1'b1, 16'h0800, 2'd0, 1'b0, 16'h0014);
        do_look(16'h0010);
        chk("R5 back to taken", 32'(lk_taken), 1);

        // R6 / R9: taken to a new target, rewritten in place as a call
        resolve(16'h0010, 1'b1, 16'h0900, 2'd2, 1'b1, 16'h0800);
        do_look(16'h0010);
        chk("R6 new target", 32'(lk_target), 32'h0900);
        chk("R4 call kind", 32'(lk_type), 2);

        // R8: alias above the tag shares the entry
        do_look(16'h0090);
        chk("R8 alias hit", 32'(lk_hit), 1);
        chk("R8 alias target", 32'(lk_target), 32'h0900);

        // R7: fill set 0, then evict
        resolve(16'h0020, 1'b1, 16'h0A00, 2'd3, 1'b0, 16'h0024);
        resolve(16'h0030, 1'b1, 16'h0B00, 2'd3, 1'b0, 16'h0034);
        resolve(16'h0040, 1'b1, 16'h0C00, 2'd1, 1'b0, 16'h0044);
        resolve(16'h0050, 1'b1, 16'h0D00, 2'd3, 1'b0, 16'h0054);
        do_look(16'h0010);
        chk("R7 way0 evicted", 32'(lk_hit), 0);
        do_look(16'h0020);
        chk("R7 way1 kept", 32'(lk_hit), 1);
        resolve(16'h0030, 1'b1, 16'h0B00, 2'd3, 1'b1, 16'h0B00);
        resolve(16'h0060, 1'b1, 16'h0E00, 2'd3, 1'b0, 16'h0064);
        do_look(16'h0040);
        chk("R7 way3 evicted", 32'(lk_hit), 0);
        do_look(16'h0050);
        chk("R7 way0 kept", 32'(lk_hit), 1);

        // sweep: pseudo-random branch stream with aliasing and set pressure
        r = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] pc, tg, ptg;
            logic [1:0]  ty;
            logic        tk, ptk;
            r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
            pc = 16'(r[7:0]) << 2;
            ty = pc[5:4] ^ pc[9:8];
            tk = (ty != 2'd0) ? 1'b1 : (r[10] | r[11]);
            tg = pc ^ (r[13] ? 16'h1230 : 16'h4560);
            look_model(pc, pt, pn);
            ptk = pt;
            ptg = pn;
            if (r[15:14] == 2'b00) begin
                ptk = !pt;
                ptg = ptk ? tg : pc + 16'd4;
            end
            resolve(pc, tk, tg, ty, ptk, ptg);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule